// File: doc/BRIEF.md
# Shadowed Match-Register PWM Timer

This block is a free-running timer with a programmable prescaler and seven compare channels. It drives six single-edge PWM outputs and one interrupt flag per channel. Channel 0 sets the period. When the timer counter equals the channel 0 value on a counting step, the counter restarts, and that event opens every PWM output. Channels 1 to 6 each close their own output when the counter reaches their value.

Each compare channel has two registers: a shadow that software writes and an active copy that the comparator uses. In plain timer mode a write goes straight to the active copy. In PWM mode a write stays in the shadow. It moves to the active copy only at the next period restart, and only if software has armed that channel's latch bit. This keeps the duty cycle glitch-free.

A second enable path lets two instances count in lockstep. The master instance exports a gate and a run signal. When its gate is on, every instance wired to it follows the master's run signal and ignores its own enable.

Top module: `pwm_shadow_timer`

## Requirements
- R1: When the effective enable is 1, the prescale counter counts 0..P and then wraps, where P is the value at address 1. The timer counter steps once per wrap, so it advances by one every P+1 cycles. When the effective enable is 0, both counters hold.
- R2: While control bit 1 (counter reset) is 1, both counters are cleared to 0 on every clock edge. Counting resumes only after software writes the bit back to 0.
- R3: A match-0 event occurs when the timer equals the active channel 0 value on a counting step. On this event the timer restarts at 1 if control bit 3 (PWM mode) is set, and at 0 otherwise.
- R4: In timer mode, a write to compare channel n (address 8+n) updates its active value at once.
- R5: In PWM mode, a compare write only updates the shadow. At the next match-0 event, each channel whose latch bit n (address 2) is set copies its shadow into its active register. All latch bits are then cleared. A channel with its latch bit clear keeps its old active value.
- R6: A match-0 event drives every PWM output high. A match on channel n (n = 1..6) drives output bit n-1 low. If both happen at once, the output stays high.
- R7: A match on channel n sets flag bit n of `irq_o`. Writing 1 to bit n at address 3 clears the flag. If a clear and a match land in the same cycle, the flag stays set.
- R8: On the master, `sync_gate_o` reflects control bit 4. On a slave, that bit reads 0 and `sync_gate_o` stays 0. When `sync_gate_i` is 1, counting follows `sync_run_i` and the instance's own enable (control bit 0) is ignored.
- R9: `ctrl_o` holds enable at bit 0, counter reset at bit 1, PWM mode at bit 3 and master gate at bit 4. Writes to bits 2 and 7:5 have no effect, and those bits read 0.
- R10: After reset, the timer, control, flags and PWM outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0 control, 1 prescale, 2 latch arm, 3 flag clear, 8+n compare n |
| wr_data | input | CNT_W | Write data |
| sync_gate_i | input | 1 | Shared gate from the master: 1 selects sync_run_i as enable |
| sync_run_i | input | 1 | Shared run enable from the master |
| sync_gate_o | output | 1 | Gate exported by a master instance (0 on a slave) |
| sync_run_o | output | 1 | This instance's own enable bit |
| ctrl_o | output | 8 | Control register contents |
| tc_o | output | CNT_W | Timer counter value |
| pwm_o | output | NUM_CH-1 | PWM outputs, bit n-1 belongs to channel n |
| irq_o | output | NUM_CH | Per-channel match flags |

## Verification
A wrong shadow, active or latch state does not show up at the moment it goes wrong. It shows up as a wrong duty cycle on `pwm_o`, one full period after the next match-0 event. The bench therefore aligns to the channel 0 flag and then counts the high cycles over exactly one period. A fault in the prescale or restart logic shows up in `tc_o` within P+1 cycles, as a step of the wrong size or a restart at the wrong value. Lockstep faults show up as two instances whose counter values drift apart.

// File: rtl/pwm_shadow_pkg.sv
`timescale 1ns/1ps
package pwm_shadow_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL     = 4'h0;
  localparam logic [ADDR_W-1:0] A_PRESCALE = 4'h1;
  localparam logic [ADDR_W-1:0] A_LATCH    = 4'h2;
  localparam logic [ADDR_W-1:0] A_FLAGCLR  = 4'h3;
  localparam int MATCH_BASE = 8;

  // bit order is software-visible: enable 0, reset 1, pwm 3, gate 4
  typedef struct packed {
    logic [2:0] rsvd_hi;
    logic       mdis;
    logic       pwm_mode;
    logic       rsvd_lo;
    logic       cnt_rst;
    logic       cnt_en;
  } ctrl_t;

  localparam logic [7:0] CTRL_MASK_MASTER = 8'h1B;
  localparam logic [7:0] CTRL_MASK_SLAVE  = 8'h0B;
endpackage

// File: rtl/pwm_ctrl_regs.sv
`timescale 1ns/1ps
module pwm_ctrl_regs
  import pwm_shadow_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int DW        = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output ctrl_t             ctrl_q,
  output logic [PRE_W-1:0]  prescale_q
);
  localparam logic [7:0] WMASK = IS_MASTER ? CTRL_MASK_MASTER : CTRL_MASK_SLAVE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      prescale_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL)
        ctrl_q <= ctrl_t'(wr_data[7:0] & WMASK);
      if (wr_addr == A_PRESCALE)
        prescale_q <= wr_data[PRE_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_prescale_counter.sv
`timescale 1ns/1ps
module pwm_prescale_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic             pwm_mode,
  input  logic             match0_hit,
  input  logic [PRE_W-1:0] prescale,
  output logic [CNT_W-1:0] tc_q,
  output logic             tick
);
  logic [PRE_W-1:0] pc_q;
  logic [CNT_W-1:0] restart_val;

  assign restart_val = {{(CNT_W-1){1'b0}}, pwm_mode};
  assign tick        = run && !clear && (pc_q == prescale);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (run) begin
      if (pc_q == prescale) begin
        pc_q <= '0;
        tc_q <= match0_hit ? restart_val : tc_q + CNT_W'(1);
      end else begin
        pc_q <= pc_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_match_bank.sv
`timescale 1ns/1ps
module pwm_match_bank
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              pwm_mode,
  input  logic              tick,
  input  logic [CNT_W-1:0]  tc,
  output logic              match0_hit,
  output logic [NUM_CH-2:0] pwm_q,
  output logic [NUM_CH-1:0] flag_q
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] latch_q;
  logic [NUM_CH-1:0] clr_mask;

  assign match0_hit = hit[0];
  assign clr_mask   = (wr_en && wr_addr == A_FLAGCLR) ? wr_data[NUM_CH-1:0] : '0;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] shad_q;
    logic [CNT_W-1:0] act_q;
    logic             wr_sel;

    assign wr_sel  = wr_en && (wr_addr == ADDR_W'(MATCH_BASE + ch));
    assign hit[ch] = tick && (tc == act_q);

    always_ff @(posedge clk) begin
      if (rst) shad_q <= '0;
      else if (wr_sel) shad_q <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst)
        act_q <= '0;
      else if (wr_sel && !pwm_mode)
        act_q <= wr_data;
      else if (pwm_mode && hit[0] && latch_q[ch])
        act_q <= shad_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      latch_q <= '0;
    else if (wr_en && wr_addr == A_LATCH)
      latch_q <= wr_data[NUM_CH-1:0];
    else if (pwm_mode && hit[0])
      latch_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= '0;
    end else begin
      for (int i = 1; i < NUM_CH; i++) begin
        if (hit[0])      pwm_q[i-1] <= 1'b1;
        else if (hit[i]) pwm_q[i-1] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_shadow_timer.sv
`timescale 1ns/1ps
module pwm_shadow_timer
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH    = 7,
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              sync_gate_i,
  input  logic              sync_run_i,
  output logic              sync_gate_o,
  output logic              sync_run_o,
  output logic [7:0]        ctrl_o,
  output logic [CNT_W-1:0]  tc_o,
  output logic [NUM_CH-2:0] pwm_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int CDW = (PRE_W > 8) ? PRE_W : 8;

  ctrl_t            ctrl;
  logic [PRE_W-1:0] prescale;
  logic             run;
  logic             tick;
  logic             match0_hit;
  logic [CNT_W-1:0] tc;

  assign run        = sync_gate_i ? sync_run_i : ctrl.cnt_en;
  assign ctrl_o     = ctrl;
  assign sync_run_o = ctrl.cnt_en;
  assign tc_o       = tc;

  if (IS_MASTER) begin : g_master
    assign sync_gate_o = ctrl.mdis;
  end else begin : g_slave
    assign sync_gate_o = 1'b0;
  end

  pwm_ctrl_regs #(.PRE_W(PRE_W), .DW(CDW), .IS_MASTER(IS_MASTER)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data[CDW-1:0]),
    .ctrl_q    (ctrl),
    .prescale_q(prescale)
  );

  pwm_prescale_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .clear     (ctrl.cnt_rst),
    .pwm_mode  (ctrl.pwm_mode),
    .match0_hit(match0_hit),
    .prescale  (prescale),
    .tc_q      (tc),
    .tick      (tick)
  );

  pwm_match_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pwm_mode  (ctrl.pwm_mode),
    .tick      (tick),
    .tc        (tc),
    .match0_hit(match0_hit),
    .pwm_q     (pwm_o),
    .flag_q    (irq_o)
  );
endmodule

// File: rtl/pwm_shadow_timer_chk.sv
`timescale 1ns/1ps
module pwm_shadow_timer_chk #(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [NUM_CH-1:0] wr_low,
  input logic              sync_gate_i,
  input logic              sync_run_i,
  input logic              ctrl_en,
  input logic              ctrl_rst,
  input logic              ctrl_pwm,
  input logic [CNT_W-1:0]  tc_o,
  input logic [NUM_CH-1:0] irq_o
);
  logic run_eff;
  assign run_eff = sync_gate_i ? sync_run_i : ctrl_en;

  // R1 and R8: no effective enable and no clear means the counter holds
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_eff && !ctrl_rst) |=> $stable(tc_o));

  // R2: the reset bit forces the counter to zero on the next edge
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    ctrl_rst |=> (tc_o == '0));

  // R3: the counter only holds, steps by one, or restarts at the mode value
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    !ctrl_rst |=> ((tc_o == $past(tc_o)) ||
                   (tc_o == $past(tc_o) + CNT_W'(1)) ||
                   (tc_o == CNT_W'($past(ctrl_pwm)))));

  // R7: a set flag stays set unless software writes 1 to clear it
  for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (irq_o[n] && !(wr_en && wr_addr == 4'd3 && wr_low[n])) |=> irq_o[n]);
  end
endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_low     (wr_data[NUM_CH-1:0]),
  .sync_gate_i(sync_gate_i),
  .sync_run_i (sync_run_i),
  .ctrl_en    (ctrl_o[0]),
  .ctrl_rst   (ctrl_o[1]),
  .ctrl_pwm   (ctrl_o[3]),
  .tc_o       (tc_o),
  .irq_o      (irq_o)
);

// File: tb/pwm_shadow_timer_tb.sv
`timescale 1ns/1ps
module pwm_shadow_timer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, s_wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        m_gate, m_run, s_gate, s_run;
  logic [7:0]  m_ctrl, s_ctrl;
  logic [15:0] m_tc, s_tc;
  logic [5:0]  m_pwm, s_pwm;
  logic [6:0]  m_irq, s_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_shadow_timer #(.IS_MASTER(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_gate_i(m_gate), .sync_run_i(m_run), .sync_gate_o(m_gate), .sync_run_o(m_run),
    .ctrl_o(m_ctrl), .tc_o(m_tc), .pwm_o(m_pwm), .irq_o(m_irq));

  pwm_shadow_timer #(.IS_MASTER(1'b0)) u_slv (
    .clk(clk), .rst(rst), .wr_en(s_wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_gate_i(m_gate), .sync_run_i(m_run), .sync_gate_o(s_gate), .sync_run_o(s_run),
    .ctrl_o(s_ctrl), .tc_o(s_tc), .pwm_o(s_pwm), .irq_o(s_irq));

  // {prescale, period, channel 1 compare}
  localparam logic [23:0] CFG [6] = '{
    {8'd0, 8'd4, 8'd2}, {8'd1, 8'd5, 8'd3}, {8'd2, 8'd3, 8'd1},
    {8'd0, 8'd6, 8'd6}, {8'd0, 8'd4, 8'd0}, {8'd3, 8'd2, 8'd5}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic swr(input logic [3:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; s_wr_en = 1'b1;
    @(negedge clk);
    s_wr_en = 1'b0;
  endtask

  // align on a fresh match-0 flag, then count high cycles of channel 1 over one period
  task automatic measure(input int period, output int highs, output int found);
    int guard = 0;
    wr(4'h3, 16'h0001);
    while (!m_irq[0] && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    found = m_irq[0];
    highs = 0;
    for (int k = 0; k < period; k++) begin
      if (m_pwm[0]) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int highs, found, guard, hold_m, hold_s;
    rst = 1'b1; wr_en = 1'b0; s_wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk("R10 tc", m_tc, 0);
    chk("R10 ctrl", m_ctrl, 0);
    chk("R10 pwm", m_pwm, 0);
    chk("R10 irq", m_irq, 0);
    chk("R10 gate", m_gate, 0);

    // R9 reserved bits ignored, field positions kept
    wr(4'h0, 16'h00E4);
    chk("R9 reserved only", m_ctrl, 0);
    repeat (3) @(negedge clk);
    chk("R9 reserved no count", m_tc, 0);
    wr(4'h0, 16'h00FF);
    chk("R9 all bits", m_ctrl, 8'h1B);
    chk("R8 master gate out", m_gate, 1);
    wr(4'h0, 16'h0000);

    // R1 prescale spacing and hold
    wr(4'h0, 16'h0002);
    wr(4'h8, 16'd1000);
    wr(4'h1, 16'd2);
    wr(4'h0, 16'h0001);
    repeat (9) @(negedge clk);
    chk("R1 three steps", m_tc, 3);
    repeat (2) @(negedge clk);
    chk("R1 within prescale", m_tc, 3);
    @(negedge clk);
    chk("R1 fourth step", m_tc, 4);
    wr(4'h0, 16'h0000);
    hold_m = int'(m_tc);
    repeat (10) @(negedge clk);
    chk("R1 hold when disabled", m_tc, hold_m);

    // R2 counter reset bit
    wr(4'h0, 16'h0001);
    repeat (4) @(negedge clk);
    wr(4'h0, 16'h0003);
    @(negedge clk);
    chk("R2 cleared", m_tc, 0);
    repeat (5) @(negedge clk);
    chk("R2 stays cleared", m_tc, 0);

    // R3 restart value by mode, R4 direct write in timer mode
    wr(4'h0, 16'h0002);
    wr(4'h1, 16'd0);
    wr(4'h8, 16'd3);
    wr(4'h3, 16'h007F);
    wr(4'h0, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R4 timer count to period", m_tc, 3);
    @(negedge clk);
    chk("R3 timer restart at 0", m_tc, 0);
    chk("R7 flag set on match 0", m_irq[0], 1);
    wr(4'h0, 16'h000A);
    wr(4'h0, 16'h0009);
    repeat (3) @(negedge clk);
    chk("R3 pwm count to period", m_tc, 3);
    @(negedge clk);
    chk("R3 pwm restart at 1", m_tc, 1);

    // R7 clear and match-wins
    wr(4'h0, 16'h000A);
    wr(4'h3, 16'h007F);
    wr(4'h0, 16'h0009);
    guard = 0;
    while (!m_irq[0] && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk("R7 flag seen", m_irq[0], 1);
    wr(4'h3, 16'h0001);
    chk("R7 clear by write", m_irq[0], 0);
    @(negedge clk);
    wr(4'h3, 16'h0001);
    chk("R7 match wins over clear", m_irq[0], 1);

    // R4 R6 duty table
    for (int e = 0; e < 6; e++) begin
      int pre, per, mr1, period, exp_hi;
      pre = int'(CFG[e][23:16]);
      per = int'(CFG[e][15:8]);
      mr1 = int'(CFG[e][7:0]);
      period = per * (pre + 1);
      exp_hi = (mr1 == 0 || mr1 >= per) ? period : mr1 * (pre + 1);
      wr(4'h0, 16'h0002);
      wr(4'h1, 16'(pre));
      wr(4'h8, 16'(per));
      wr(4'h9, 16'(mr1));
      wr(4'h0, 16'h0009);
      measure(period, highs, found);
      chk("R6 period aligned", found, 1);
      chk("R4 R6 duty high cycles", highs, exp_hi);
    end

    // R5 shadow, latch arm, latch auto-clear
    wr(4'h0, 16'h0002);
    wr(4'h1, 16'd0);
    wr(4'h8, 16'd3);
    wr(4'h9, 16'd2);
    wr(4'h0, 16'h0009);
    measure(3, highs, found);
    chk("R5 baseline duty", highs, 2);
    wr(4'h9, 16'd1);
    measure(3, highs, found);
    chk("R5 unarmed write ignored", highs, 2);
    wr(4'h2, 16'h0002);
    measure(3, highs, found);
    chk("R5 armed write applied", highs, 1);
    wr(4'h9, 16'd2);
    measure(3, highs, found);
    chk("R5 latch cleared after transfer", highs, 1);

    // R8 master/slave lockstep
    wr(4'h0, 16'h0002);
    wr(4'h8, 16'd1000);
    wr(4'h1, 16'd0);
    swr(4'h0, 16'h0012);
    chk("R8 slave gate bit reads 0", s_ctrl, 8'h02);
    chk("R8 slave gate out", s_gate, 0);
    swr(4'h8, 16'd1000);
    swr(4'h0, 16'h0000);
    wr(4'h0, 16'h0011);
    repeat (5) @(negedge clk);
    chk("R8 master count", m_tc, 5);
    chk("R8 slave follows master", s_tc, 5);
    wr(4'h0, 16'h0010);
    hold_m = int'(m_tc);
    repeat (4) @(negedge clk);
    chk("R8 master stopped by gate", m_tc, hold_m);
    chk("R8 slave stopped by gate", s_tc, hold_m);
    wr(4'h0, 16'h0000);
    hold_s = int'(s_tc);
    swr(4'h0, 16'h0001);
    repeat (4) @(negedge clk);
    chk("R8 slave own enable", s_tc, hold_s + 4);
    chk("R8 master idle", m_tc, hold_m);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule